// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command register of a byte-wide parallel flash device. It watches the device's bus write cycles, formed from chip enable, write enable and output enable, together with an address bus and a data byte. It recognises the fixed unlock sequences and turns each completed sequence into a single-cycle request for the array controller. The requests are byte program (with target address and data), sector erase (with sector index), block erase (with block index), chip erase, identification entry and identification exit. The block also keeps an identification-mode flag. While that flag is set, reads return the manufacturer and device codes in place of the array data.

The decoder is one flat state machine. Its states are `ST_IDLE`, `ST_UNLOCK1` (first unlock byte seen), `ST_UNLOCK2` (both unlock bytes seen), `ST_PROG_ARMED` (program opcode seen), `ST_ERASE_SETUP` (erase opcode seen), `ST_ERASE_UNLOCK1` and `ST_ERASE_UNLOCK2` (second unlock pair).

The transitions are:
- `ST_IDLE` goes to `ST_UNLOCK1` on AAh to 555h.
- `ST_UNLOCK1` goes to `ST_UNLOCK2` on 55h to 2AAh.
- `ST_UNLOCK2` goes to `ST_PROG_ARMED` on A0h to 555h, or to `ST_ERASE_SETUP` on 80h to 555h. It returns to `ST_IDLE` and issues identification entry on 90h to 555h, or identification exit on F0h to 555h.
- `ST_PROG_ARMED` returns to `ST_IDLE` on any write and issues a program request.
- `ST_ERASE_SETUP` goes to `ST_ERASE_UNLOCK1` on AAh to 555h.
- `ST_ERASE_UNLOCK1` goes to `ST_ERASE_UNLOCK2` on 55h to 2AAh.
- `ST_ERASE_UNLOCK2` returns to `ST_IDLE` and issues chip, sector or block erase.
- Any other write returns the machine to `ST_IDLE`.

When the array controller is busy, accepted writes are discarded.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A bus write is active in each clock cycle where ce_n=0, we_n=0 and oe_n=1. The write is processed in the first cycle after it becomes inactive. The address is taken from the first active cycle and the data from the last active cycle. Cycles with oe_n=0 never form a write.
- R2: Every command starts with AAh to address 555h, then 55h to address 2AAh. Unlock addresses are compared on address bits [10:0] only.
- R3: After the unlock pair, A0h to 555h arms programming. The next write then produces a one-cycle prog_req with prog_addr and prog_data equal to that write's address and data.
- R4: After the unlock pair, the write sequence 80h to 555h, AAh to 555h, 55h to 2AAh arms erase. The final write selects the erase type:
  - 10h to 555h gives chip_erase.
  - 30h to any address gives sect_erase, with sect_idx = addr[18:12].
  - 50h to any address gives blk_erase, with blk_idx = addr[18:16].
- R5: With HAS_BLOCKS=0, the 50h final write issues no command, and the decoder returns to idle.
- R6: After the unlock pair, 90h to 555h pulses id_enter and sets id_mode. While id_mode=1, rd_data depends on addr[15:0]:
  - 0 gives MFR_ID (9Dh).
  - 1 gives DEV_ID (3Eh).
  - Any other value gives 00h.

  While id_mode=0, rd_data equals array_rdata.
- R7: Two sequences pulse id_exit and clear id_mode: F0h to 555h after the unlock pair, or a single F0h to any address from idle.
- R8: A write that does not match the next expected cycle returns the decoder to idle and issues no command.
- R9: While busy=1, writes are discarded and the decoder state does not change.
- R10: Every command output is a one-cycle pulse, and at most one is high in any cycle. After reset all pulses are low and id_mode=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Array operation in progress; writes are discarded |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Bus write data |
| array_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data presented on the bus |
| prog_req | output | 1 | Byte program request pulse |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | 8 | Program data byte |
| sect_erase | output | 1 | Sector erase request pulse |
| sect_idx | output | ADDR_W-SECTOR_W | Sector to erase |
| blk_erase | output | 1 | Block erase request pulse |
| blk_idx | output | ADDR_W-BLOCK_W | Block to erase |
| chip_erase | output | 1 | Chip erase request pulse |
| id_enter | output | 1 | Identification entry pulse |
| id_exit | output | 1 | Identification exit pulse |
| id_mode | output | 1 | Identification mode flag |

## Verification
A wrong decoder state shows at the ports on the first write after the fault. A lost state makes a valid sequence end without its pulse. A stale state makes a stray or misplaced write produce a command, one cycle after that write's strobe rises. A wrong identification flag shows at once on rd_data, because the read path is combinational. The scoreboard therefore expects a specific pulse with its payload after each final write, and it flags any pulse it did not expect.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CODE_UNLOCK_A  = 8'hAA;
    localparam logic [7:0] CODE_UNLOCK_B  = 8'h55;
    localparam logic [7:0] CODE_PROGRAM   = 8'hA0;
    localparam logic [7:0] CODE_ERASE     = 8'h80;
    localparam logic [7:0] CODE_ID_ENTER  = 8'h90;
    localparam logic [7:0] CODE_ID_EXIT   = 8'hF0;
    localparam logic [7:0] CODE_CHIP      = 8'h10;
    localparam logic [7:0] CODE_SECTOR    = 8'h30;
    localparam logic [7:0] CODE_BLOCK     = 8'h50;

    localparam int         UNLOCK_W       = 11;
    localparam logic [UNLOCK_W-1:0] ADDR_FIRST  = 11'h555;
    localparam logic [UNLOCK_W-1:0] ADDR_SECOND = 11'h2AA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLOCK1,
        ST_UNLOCK2,
        ST_PROG_ARMED,
        ST_ERASE_SETUP,
        ST_ERASE_UNLOCK1,
        ST_ERASE_UNLOCK2
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_PROGRAM,
        CMD_SECTOR_ERASE,
        CMD_BLOCK_ERASE,
        CMD_CHIP_ERASE,
        CMD_ID_ENTER,
        CMD_ID_EXIT
    } cmd_t;

endpackage

// File: rtl/bus_write_capture.sv
module bus_write_capture #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    logic              act;
    logic              act_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;

    assign act = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) begin
                addr_q <= addr;
            end
            if (act) begin
                data_q <= wdata;
            end
        end
    end

    assign wr_stb  = act_q && !act;
    assign wr_addr = addr_q;
    assign wr_data = data_q;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && act) |=> $stable(addr_q)); // R1

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int SECTOR_W   = 12,
    parameter int BLOCK_W    = 16,
    parameter bit HAS_BLOCKS = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       busy,
    input  logic                       wr_stb,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [7:0]                 wr_data,
    output logic                       prog_req,
    output logic [ADDR_W-1:0]          prog_addr,
    output logic [7:0]                 prog_data,
    output logic                       sect_erase,
    output logic [ADDR_W-SECTOR_W-1:0] sect_idx,
    output logic                       blk_erase,
    output logic [ADDR_W-BLOCK_W-1:0]  blk_idx,
    output logic                       chip_erase,
    output logic                       id_enter,
    output logic                       id_exit,
    output logic                       id_mode
);

    localparam int SECT_IDX_W = ADDR_W - SECTOR_W;
    localparam int BLK_IDX_W  = ADDR_W - BLOCK_W;

    seq_state_t state, nxt_state;
    cmd_t       nxt_cmd;
    logic       blk_ok;
    logic       at_first, at_second;

    generate
        if (HAS_BLOCKS) begin : g_blocks
            assign blk_ok = 1'b1;
        end else begin : g_single_block
            assign blk_ok = 1'b0;
        end
    endgenerate

    assign at_first  = (wr_addr[UNLOCK_W-1:0] == ADDR_FIRST);
    assign at_second = (wr_addr[UNLOCK_W-1:0] == ADDR_SECOND);

    always_comb begin
        nxt_state = state;
        nxt_cmd   = CMD_NONE;
        if (wr_stb && !busy) begin
            nxt_state = ST_IDLE;
            unique case (state)
                ST_IDLE: begin
                    if (at_first && wr_data == CODE_UNLOCK_A) begin
                        nxt_state = ST_UNLOCK1;
                    end else if (wr_data == CODE_ID_EXIT) begin
                        nxt_cmd = CMD_ID_EXIT;
                    end
                end
                ST_UNLOCK1: begin
                    if (at_second && wr_data == CODE_UNLOCK_B) begin
                        nxt_state = ST_UNLOCK2;
                    end
                end
                ST_UNLOCK2: begin
                    if (at_first) begin
                        if (wr_data == CODE_PROGRAM) begin
                            nxt_state = ST_PROG_ARMED;
                        end else if (wr_data == CODE_ERASE) begin
                            nxt_state = ST_ERASE_SETUP;
                        end else if (wr_data == CODE_ID_ENTER) begin
                            nxt_cmd = CMD_ID_ENTER;
                        end else if (wr_data == CODE_ID_EXIT) begin
                            nxt_cmd = CMD_ID_EXIT;
                        end
                    end
                end
                ST_PROG_ARMED: begin
                    nxt_cmd = CMD_PROGRAM;
                end
                ST_ERASE_SETUP: begin
                    if (at_first && wr_data == CODE_UNLOCK_A) begin
                        nxt_state = ST_ERASE_UNLOCK1;
                    end
                end
                ST_ERASE_UNLOCK1: begin
                    if (at_second && wr_data == CODE_UNLOCK_B) begin
                        nxt_state = ST_ERASE_UNLOCK2;
                    end
                end
                ST_ERASE_UNLOCK2: begin
                    if (at_first && wr_data == CODE_CHIP) begin
                        nxt_cmd = CMD_CHIP_ERASE;
                    end else if (wr_data == CODE_SECTOR) begin
                        nxt_cmd = CMD_SECTOR_ERASE;
                    end else if (wr_data == CODE_BLOCK && blk_ok) begin
                        nxt_cmd = CMD_BLOCK_ERASE;
                    end
                end
                default: begin
                    nxt_state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_req   <= 1'b0;
            prog_addr  <= '0;
            prog_data  <= '0;
            sect_erase <= 1'b0;
            sect_idx   <= '0;
            blk_erase  <= 1'b0;
            blk_idx    <= '0;
            chip_erase <= 1'b0;
            id_enter   <= 1'b0;
            id_exit    <= 1'b0;
            id_mode    <= 1'b0;
        end else begin
            prog_req   <= (nxt_cmd == CMD_PROGRAM);
            sect_erase <= (nxt_cmd == CMD_SECTOR_ERASE);
            blk_erase  <= (nxt_cmd == CMD_BLOCK_ERASE);
            chip_erase <= (nxt_cmd == CMD_CHIP_ERASE);
            id_enter   <= (nxt_cmd == CMD_ID_ENTER);
            id_exit    <= (nxt_cmd == CMD_ID_EXIT);
            if (nxt_cmd == CMD_PROGRAM) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (nxt_cmd == CMD_SECTOR_ERASE) begin
                sect_idx <= wr_addr[ADDR_W-1:ADDR_W-SECT_IDX_W];
            end
            if (nxt_cmd == CMD_BLOCK_ERASE) begin
                blk_idx <= wr_addr[ADDR_W-1:ADDR_W-BLK_IDX_W];
            end
            if (nxt_cmd == CMD_ID_ENTER) begin
                id_mode <= 1'b1;
            end else if (nxt_cmd == CMD_ID_EXIT) begin
                id_mode <= 1'b0;
            end
        end
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, sect_erase, blk_erase, chip_erase, id_enter, id_exit})); // R10

    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb) |=> (state == $past(state)) &&
            !(prog_req || sect_erase || blk_erase || chip_erase || id_enter || id_exit)); // R9

    AST_PROG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> ($past(state) == ST_PROG_ARMED)); // R3

    AST_BLOCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        blk_erase |-> blk_ok); // R5

    AST_ID_ENTER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        id_enter |-> id_mode); // R6

    AST_ID_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        id_exit |-> !id_mode); // R7

endmodule

// File: rtl/id_read_mux.sv
module id_read_mux #(
    parameter int         OFS_W  = 16,
    parameter logic [7:0] MFR_ID = 8'h9D,
    parameter logic [7:0] DEV_ID = 8'h3E
) (
    input  logic             id_mode,
    input  logic [OFS_W-1:0] rd_ofs,
    input  logic [7:0]       array_rdata,
    output logic [7:0]       rd_data
);

    always_comb begin
        if (!id_mode) begin
            rd_data = array_rdata;
        end else if (rd_ofs == OFS_W'(0)) begin
            rd_data = MFR_ID;
        end else if (rd_ofs == OFS_W'(1)) begin
            rd_data = DEV_ID;
        end else begin
            rd_data = 8'h00;
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int         ADDR_W     = 19,
    parameter int         SECTOR_W   = 12,
    parameter int         BLOCK_W    = 16,
    parameter bit         HAS_BLOCKS = 1'b1,
    parameter logic [7:0] MFR_ID     = 8'h9D,
    parameter logic [7:0] DEV_ID     = 8'h3E
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_n,
    input  logic                       we_n,
    input  logic                       oe_n,
    input  logic                       busy,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [7:0]                 wdata,
    input  logic [7:0]                 array_rdata,
    output logic [7:0]                 rd_data,
    output logic                       prog_req,
    output logic [ADDR_W-1:0]          prog_addr,
    output logic [7:0]                 prog_data,
    output logic                       sect_erase,
    output logic [ADDR_W-SECTOR_W-1:0] sect_idx,
    output logic                       blk_erase,
    output logic [ADDR_W-BLOCK_W-1:0]  blk_idx,
    output logic                       chip_erase,
    output logic                       id_enter,
    output logic                       id_exit,
    output logic                       id_mode
);

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;

    bus_write_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    cmd_seq_fsm #(
        .ADDR_W     (ADDR_W),
        .SECTOR_W   (SECTOR_W),
        .BLOCK_W    (BLOCK_W),
        .HAS_BLOCKS (HAS_BLOCKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .sect_erase (sect_erase),
        .sect_idx   (sect_idx),
        .blk_erase  (blk_erase),
        .blk_idx    (blk_idx),
        .chip_erase (chip_erase),
        .id_enter   (id_enter),
        .id_exit    (id_exit),
        .id_mode    (id_mode)
    );

    id_read_mux #(
        .OFS_W  (BLOCK_W),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_id_mux (
        .id_mode     (id_mode),
        .rd_ofs      (addr[BLOCK_W-1:0]),
        .array_rdata (array_rdata),
        .rd_data     (rd_data)
    );

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;

    localparam logic [2:0] K_PROG = 3'd1;
    localparam logic [2:0] K_SECT = 3'd2;
    localparam logic [2:0] K_BLK  = 3'd3;
    localparam logic [2:0] K_CHIP = 3'd4;
    localparam logic [2:0] K_ENT  = 3'd5;
    localparam logic [2:0] K_EXIT = 3'd6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    array_rdata = 8'hC3;

    logic [7:0]    rd_data;
    logic          prog_req, sect_erase, blk_erase, chip_erase, id_enter, id_exit, id_mode;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_data;
    logic [6:0]    sect_idx;
    logic [2:0]    blk_idx;

    logic [7:0]    nb_rd_data;
    logic          nb_prog_req, nb_sect_erase, nb_blk_erase, nb_chip_erase;
    logic          nb_id_enter, nb_id_exit, nb_id_mode;
    logic [AW-1:0] nb_prog_addr;
    logic [7:0]    nb_prog_data;
    logic [6:0]    nb_sect_idx;
    logic [2:0]    nb_blk_idx;

    typedef struct {
        logic [2:0]  kind;
        logic [31:0] a;
        logic [7:0]  d;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .busy(busy),
        .addr(addr), .wdata(wdata), .array_rdata(array_rdata), .rd_data(rd_data),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .sect_erase(sect_erase), .sect_idx(sect_idx), .blk_erase(blk_erase),
        .blk_idx(blk_idx), .chip_erase(chip_erase), .id_enter(id_enter),
        .id_exit(id_exit), .id_mode(id_mode)
    );

    flash_cmd_decoder #(.HAS_BLOCKS(1'b0)) i_flash_cmd_decoder_nb (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .busy(busy),
        .addr(addr), .wdata(wdata), .array_rdata(array_rdata), .rd_data(nb_rd_data),
        .prog_req(nb_prog_req), .prog_addr(nb_prog_addr), .prog_data(nb_prog_data),
        .sect_erase(nb_sect_erase), .sect_idx(nb_sect_idx), .blk_erase(nb_blk_erase),
        .blk_idx(nb_blk_idx), .chip_erase(nb_chip_erase), .id_enter(nb_id_enter),
        .id_exit(nb_id_exit), .id_mode(nb_id_mode)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_cmd(input logic [2:0] k, input logic [31:0] a,
                              input logic [7:0] d, input string req);
        exp_t e;
        e.kind = k; e.a = a; e.d = d; e.req = req;
        exp_q.push_back(e);
    endtask

    function automatic logic any_pulse();
        return prog_req | sect_erase | blk_erase | chip_erase | id_enter | id_exit;
    endfunction

    // Scoreboard monitor: pops one expected item for every command pulse.
    logic [2:0]  obs_kind;
    logic [31:0] obs_a;
    logic [7:0]  obs_d;
    int          obs_cnt;
    exp_t        cur;
    always @(negedge clk) begin
        if (rst_n) begin
            obs_cnt = $countones({prog_req, sect_erase, blk_erase, chip_erase, id_enter, id_exit});
            obs_a = '0;
            obs_d = '0;
            obs_kind = 3'd0;
            if (prog_req)   begin obs_kind = K_PROG; obs_a = 32'(prog_addr); obs_d = prog_data; end
            if (sect_erase) begin obs_kind = K_SECT; obs_a = 32'(sect_idx); end
            if (blk_erase)  begin obs_kind = K_BLK;  obs_a = 32'(blk_idx); end
            if (chip_erase) obs_kind = K_CHIP;
            if (id_enter)   obs_kind = K_ENT;
            if (id_exit)    obs_kind = K_EXIT;
            if (obs_cnt > 1) check(1'b0, "R10 more than one pulse", 32'(obs_cnt), 32'd1);
            if (obs_cnt != 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected command", 32'(obs_kind), 32'd0);
                end else begin
                    cur = exp_q.pop_front();
                    check(obs_kind == cur.kind && obs_a == cur.a && obs_d == cur.d, cur.req,
                          {obs_kind, 5'd0, obs_a[15:0], obs_d}, {cur.kind, 5'd0, cur.a[15:0], cur.d});
                end
            end
        end
    end

    // One bus write: address/data in first and second active cycles may differ.
    task automatic bus_wr2(input logic [AW-1:0] a1, input logic [AW-1:0] a2,
                           input logic [7:0] d1, input logic [7:0] d2, input bit oe_low);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = oe_low ? 1'b0 : 1'b1;
        addr = a1; wdata = d1;
        @(negedge clk);
        addr = a2; wdata = d2;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        bus_wr2(a, a, d, d, 1'b0);
    endtask

    task automatic unlock();
        bus_wr(19'h00555, 8'hAA);
        bus_wr(19'h002AA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        bus_wr(19'h00555, 8'h80);
        unlock();
    endtask

    task automatic read_at(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        check(rd_data == exp, req, 32'(rd_data), 32'(exp));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        check(1'b0, "R10 watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!any_pulse(), "R10 reset pulses", 32'(any_pulse()), 32'd0);
        check(id_mode == 1'b0, "R10 reset id_mode", 32'(id_mode), 32'd0);
        rst_n = 1'b1;
        read_at(19'h00000, 8'hC3, "R6 normal read passthrough");

        // R3: basic program
        unlock();
        bus_wr(19'h00555, 8'hA0);
        expect_cmd(K_PROG, 32'h01234, 8'h5A, "R3 program");
        bus_wr(19'h01234, 8'h5A);
        @(negedge clk);
        check(!prog_req, "R10 pulse width", 32'(prog_req), 32'd0);

        // R2: upper unlock address bits are don't-care
        bus_wr(19'h7D555, 8'hAA);
        bus_wr(19'h432AA, 8'h55);
        bus_wr(19'h1F555, 8'hA0);
        expect_cmd(K_PROG, 32'h7FFFF, 8'h00, "R2 unlock upper bits ignored");
        bus_wr(19'h7FFFF, 8'h00);

        // R1: address from first active cycle, data from last
        unlock();
        bus_wr(19'h00555, 8'hA0);
        expect_cmd(K_PROG, 32'h12345, 8'h66, "R1 address first, data last");
        bus_wr2(19'h12345, 19'h54321, 8'h11, 8'h66, 1'b0);

        // R4: sector, block, chip erase
        erase_prefix();
        expect_cmd(K_SECT, 32'h3A, 8'h00, "R4 sector erase");
        bus_wr(19'h3A123, 8'h30);
        erase_prefix();
        expect_cmd(K_BLK, 32'h5, 8'h00, "R4 block erase");
        bus_wr(19'h5FFFF, 8'h50);
        // R5: single-block variant rejects it
        check(!nb_blk_erase, "R5 block erase rejected", 32'(nb_blk_erase), 32'd0);
        erase_prefix();
        expect_cmd(K_CHIP, 32'h0, 8'h00, "R4 chip erase");
        bus_wr(19'h00555, 8'h10);

        // R6: identification mode reads
        unlock();
        expect_cmd(K_ENT, 32'h0, 8'h00, "R6 id entry");
        bus_wr(19'h00555, 8'h90);
        check(id_mode, "R6 id_mode set", 32'(id_mode), 32'd1);
        read_at(19'h00000, 8'h9D, "R6 manufacturer code");
        read_at(19'h00001, 8'h3E, "R6 device code");
        read_at(19'h70000, 8'h9D, "R6 upper offset bits ignored");
        read_at(19'h00002, 8'h00, "R6 other offset");

        // R7: single-write exit
        expect_cmd(K_EXIT, 32'h0, 8'h00, "R7 single-write exit");
        bus_wr(19'h01234, 8'hF0);
        check(!id_mode, "R7 id_mode cleared", 32'(id_mode), 32'd0);
        read_at(19'h00000, 8'hC3, "R7 normal read after exit");

        // R7: three-cycle exit
        unlock();
        expect_cmd(K_ENT, 32'h0, 8'h00, "R6 id entry again");
        bus_wr(19'h00555, 8'h90);
        unlock();
        expect_cmd(K_EXIT, 32'h0, 8'h00, "R7 three-cycle exit");
        bus_wr(19'h00555, 8'hF0);
        check(!id_mode, "R7 id_mode cleared by sequence", 32'(id_mode), 32'd0);

        // R8: mismatches return to idle
        unlock();
        bus_wr(19'h00555, 8'h77);
        bus_wr(19'h00555, 8'hA0);
        bus_wr(19'h00100, 8'h12);
        check(!any_pulse(), "R8 bad third cycle", 32'(any_pulse()), 32'd0);
        bus_wr(19'h00555, 8'hAA);
        bus_wr(19'h002AB, 8'h55);
        bus_wr(19'h00555, 8'hA0);
        bus_wr(19'h00100, 8'h12);
        check(!any_pulse(), "R8 bad unlock address", 32'(any_pulse()), 32'd0);
        unlock();
        bus_wr(19'h00555, 8'h80);
        bus_wr(19'h00555, 8'hAA);
        bus_wr(19'h00555, 8'hAA);
        bus_wr(19'h10000, 8'h30);
        check(!any_pulse(), "R8 bad erase unlock", 32'(any_pulse()), 32'd0);

        // R1: a cycle with oe_n low is not a write
        unlock();
        bus_wr2(19'h00555, 19'h00555, 8'hA0, 8'hA0, 1'b1);
        bus_wr2(19'h00200, 19'h00200, 8'h33, 8'h33, 1'b1);
        check(!any_pulse(), "R1 oe low ignored", 32'(any_pulse()), 32'd0);
        bus_wr(19'h00555, 8'hA0);
        expect_cmd(K_PROG, 32'h00200, 8'h44, "R1 sequence kept across oe-low write");
        bus_wr(19'h00200, 8'h44);

        // R9: busy discards writes without changing state
        busy = 1'b1;
        unlock();
        busy = 1'b0;
        bus_wr(19'h00555, 8'hA0);
        bus_wr(19'h00300, 8'h21);
        check(!any_pulse(), "R9 busy unlock discarded", 32'(any_pulse()), 32'd0);
        unlock();
        bus_wr(19'h00555, 8'hA0);
        busy = 1'b1;
        bus_wr(19'h00300, 8'h21);
        check(!prog_req, "R9 busy program discarded", 32'(prog_req), 32'd0);
        busy = 1'b0;
        expect_cmd(K_PROG, 32'h00301, 8'h22, "R9 armed state kept under busy");
        bus_wr(19'h00301, 8'h22);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all expected commands seen", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule